// File: doc/BRIEF.md
# Interrupt Control and Status Register with Port-Change Watch

This block is the interrupt control register of a small 8-bit controller core. It holds one byte made of five enable bits and three sticky source flags. The three sources are a timer overflow pulse, an external interrupt pin and a change on a four-pin group of an I/O port. The block synchronizes the asynchronous pins and finds rising edges on the external pin. It watches the port group against a snapshot taken on every port read, latches the flags and combines the flags with the enables into one interrupt request line to the core.

Software reaches the byte through a simple bus. It is a combinational read path and a one-cycle write strobe, decoded at four mirrored addresses. Two small state machines do the pin work. The rise detector has the states `LVL_LOW` and `LVL_HIGH`. Its only flagging transition is `LVL_LOW -> LVL_HIGH`, taken when the synchronized pin reads 1. The port watcher has the states `PC_SAME` and `PC_DIFF`. It moves from `PC_SAME` to `PC_DIFF` when the synchronized pins differ from the snapshot. It moves from `PC_DIFF` back to `PC_SAME` on a port read or when the pins return to the snapshot. While the watcher is in `PC_DIFF` it keeps setting the port-change flag.

Top module: `irq_ctl_reg`

## Requirements
- R1: The byte layout, from bit 7 down to bit 0, is as follows. Bit 7 is the global enable, bit 6 the peripheral enable, bit 5 the timer enable, bit 4 the pin enable and bit 3 the port-change enable. Bit 2 is the timer flag, bit 1 the pin flag and bit 0 the port-change flag. The byte is written and read identically at addresses 0x00B, 0x08B, 0x10B and 0x18B.
- R2: Each flag sets on its condition whatever the state of its own enable bit and of the global enable.
- R3: A flag never clears by itself. Only a write that carries 0 in its bit position clears it.
- R4: A timer overflow pulse sets the timer flag at the next clock edge.
- R5: The external pin passes through two synchronizing flops. Its flag sets on the third rising clock edge after the pin goes high. A pin that stays high or falls sets nothing.
- R6: After two synchronizing flops, a difference between the four port pins and the value taken at the last port read moves the watcher to `PC_DIFF`. The port-change flag then sets at the following edge, so it sets on the fourth edge after the pins change.
- R7: While the difference persists, a write of 0 to the port-change flag does not stick. After a port-read strobe, a write of 0 clears it.
- R8: When a hardware set and a write of 0 hit the same flag in one cycle, the flag ends up 1.
- R9: `irq_req` is the global enable ANDed with the OR of four terms: each flag ANDed with its own enable, and the peripheral enable ANDed with `periph_pend`.
- R10: After reset the byte reads 0x00 and `irq_req` is 0, provided the port pins are 0.
- R11: Writes to any other address leave the byte unchanged, and reads from any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Register address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; the byte on an address hit, otherwise 0 |
| port_rd_stb | input | 1 | Port read strobe; takes a new snapshot of the port pins |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_hi | input | 4 | Watched port pins, asynchronous |
| periph_pend | input | 1 | Pending request from the peripheral group |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench first aims at the clear that does not stick. A design that cleared the port-change flag while the pins still differed from the snapshot would read 0x00 where 0x01 is expected. A design that ignored the port-read strobe would never let the flag clear at all. It also drives a write of 0 on the same cycle as a timer pulse, where a design in which the write wins would lose the event. The pin tests check the exact edge on which the flag appears and that a held-high or falling pin sets nothing, which catches a missing synchronizer stage or a level detector. A random phase mixes mirrored and non-matching addresses with enables, timer pulses and peripheral requests, so that a wrong bank decode or a wrong term in the request equation shows up against the bench's own model.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 3;
    localparam int OFS_W   = 7;

    localparam int B_GIE  = 7;
    localparam int B_PEIE = 6;
    localparam int B_TIE  = 5;
    localparam int B_EIE  = 4;
    localparam int B_PIE  = 3;
    localparam int B_TFL  = 2;
    localparam int B_EFL  = 1;
    localparam int B_PFL  = 0;

    typedef enum logic {PC_SAME, PC_DIFF} pc_state_e;
    typedef enum logic {LVL_LOW, LVL_HIGH} lvl_state_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_rise_fsm.sv
module irq_rise_fsm
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (lvl) begin
                    state_d = LVL_HIGH;
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!lvl) state_d = LVL_LOW;
            end
            default: state_d = LVL_LOW;
        endcase
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch
    import irq_ctl_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_raw,
    input  logic         rd_stb,
    output logic         set_req
);
    logic [W-1:0] pins_s;
    logic [W-1:0] snap_q;
    logic         differs;
    pc_state_e    state_q, state_d;

    irq_pin_sync #(.W(W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      snap_q <= '0;
        else if (rd_stb) snap_q <= pins_s;
    end

    assign differs = (pins_s != snap_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PC_SAME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PC_SAME: if (differs && !rd_stb) state_d = PC_DIFF;
            PC_DIFF: if (rd_stb || !differs) state_d = PC_SAME;
            default: state_d = PC_SAME;
        endcase
    end

    always_comb begin
        set_req = (state_q == PC_DIFF);
    end

    AST_READ_ENDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !set_req); // R7
    AST_DIFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (differs && !rd_stb) |=> set_req); // R6
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic wr_en,
    input  logic wr_val,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= 1'b0;
        else if (hw_set) q <= 1'b1;
        else if (wr_en)  q <= wr_val;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !wr_en) |=> q); // R3
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && !hw_set && !(wr_en && wr_val)) |=> !q); // R3
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_ctl_pkg::*;
#(
    parameter int             NUM_BANKS = 4,
    parameter int             PORT_W    = 4,
    parameter logic [OFS_W-1:0] REG_OFS = 7'h0B,
    localparam int            BANK_W    = $clog2(NUM_BANKS),
    localparam int            ADDR_W    = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              port_rd_stb,
    input  logic              tmr_ovf,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              periph_pend,
    output logic              irq_req
);
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 hit;
    logic                 wr_hit;
    logic                 ext_s;
    logic                 ext_rise;
    logic                 pc_set;
    logic [NUM_SRC-1:0]   src_set;
    logic [NUM_SRC-1:0]   flag_q;
    logic [NUM_SRC-1:0]   src_en;
    logic [REG_W-NUM_SRC-1:0] ctl_q;
    logic [REG_W-1:0]     reg_val;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = (bus_addr == {BANK_W'(b), REG_OFS});
    end

    assign hit    = |bank_hit;
    assign wr_hit = hit && bus_we;

    irq_pin_sync #(.W(1), .STAGES(2)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_pin),
        .dout (ext_s)
    );

    irq_rise_fsm u_ext_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (ext_s),
        .rise (ext_rise)
    );

    irq_port_watch #(.W(PORT_W)) u_port_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_raw(port_hi),
        .rd_stb  (port_rd_stb),
        .set_req (pc_set)
    );

    assign src_set[B_TFL] = tmr_ovf;
    assign src_set[B_EFL] = ext_rise;
    assign src_set[B_PFL] = pc_set;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        irq_flag_cell u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .hw_set(src_set[i]),
            .wr_en (wr_hit),
            .wr_val(bus_wdata[i]),
            .q     (flag_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_hit) ctl_q <= bus_wdata[REG_W-1:NUM_SRC];
    end

    assign reg_val   = {ctl_q, flag_q};
    assign bus_rdata = hit ? reg_val : '0;

    assign src_en[B_TFL] = reg_val[B_TIE];
    assign src_en[B_EFL] = reg_val[B_EIE];
    assign src_en[B_PFL] = reg_val[B_PIE];

    assign irq_req = reg_val[B_GIE] &
                     ((|(flag_q & src_en)) | (reg_val[B_PEIE] & periph_pend));

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> bus_rdata[B_GIE] || !hit); // R9
    AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> flag_q[B_TFL]); // R4
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctl_q)); // R11
endmodule

// File: tb/test_irq_ctl_reg.sv
`timescale 1ns/1ps
module test_irq_ctl_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       port_rd_stb;
    logic       tmr_ovf;
    logic       ext_pin;
    logic [3:0] port_hi;
    logic       periph_pend;
    logic       irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_ctl_reg i_irq_ctl_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .port_rd_stb(port_rd_stb),
        .tmr_ovf    (tmr_ovf),
        .ext_pin    (ext_pin),
        .port_hi    (port_hi),
        .periph_pend(periph_pend),
        .irq_req    (irq_req)
    );

    function automatic logic irq_model(input logic [7:0] r, input logic pp);
        return r[7] & ((r[5] & r[2]) | (r[4] & r[1]) | (r[3] & r[0]) | (r[6] & pp));
    endfunction

    function automatic logic is_hit(input logic [8:0] a);
        return a[6:0] == 7'h0B;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick();
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] model;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_addr = 9'h00B; bus_we = 1'b0; bus_wdata = 8'h00;
        port_rd_stb = 1'b0; tmr_ovf = 1'b0; ext_pin = 1'b0; port_hi = 4'h0;
        periph_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R10 reset state
        rd(9'h00B, v); check("R10 reset byte", v, 8'h00);
        check("R10 reset irq", {7'd0, irq_req}, 8'h00);

        // R1 mirrored addresses
        wr(9'h18B, 8'hF8);
        rd(9'h08B, v); check("R1 mirror 08B", v, 8'hF8);
        rd(9'h10B, v); check("R1 mirror 10B", v, 8'hF8);
        rd(9'h00B, v); check("R1 mirror 00B", v, 8'hF8);
        check("R9 no flag no irq", {7'd0, irq_req}, 8'h00);
        wr(9'h00B, 8'h00);

        // R11 other address
        wr(9'h00C, 8'hFF);
        rd(9'h00B, v); check("R11 write ignored", v, 8'h00);
        rd(9'h00C, v); check("R11 read zero", v, 8'h00);

        // R2 R4 timer flag with enables off
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
        rd(9'h00B, v); check("R4 R2 timer flag", v, 8'h04);
        check("R2 no irq when masked", {7'd0, irq_req}, 8'h00);

        // R1 layout: global + timer enable with timer flag
        wr(9'h00B, 8'hA4);
        rd(9'h00B, v); check("R1 layout", v, 8'hA4);
        check("R9 timer irq", {7'd0, irq_req}, 8'h01);

        // R3 sticky
        repeat (5) tick();
        rd(9'h00B, v); check("R3 flag holds", v, 8'hA4);
        wr(9'h00B, 8'hA0);
        rd(9'h00B, v); check("R3 write clears", v, 8'hA0);
        check("R9 irq drops", {7'd0, irq_req}, 8'h00);

        // R8 set wins over clear
        bus_addr = 9'h00B; bus_wdata = 8'h00; bus_we = 1'b1; tmr_ovf = 1'b1;
        tick();
        bus_we = 1'b0; tmr_ovf = 1'b0;
        rd(9'h00B, v); check("R8 set wins", v, 8'h04);
        wr(9'h00B, 8'h00);

        // R5 external pin edge timing
        ext_pin = 1'b1;
        tick(); tick();
        rd(9'h00B, v); check("R5 not before third edge", v, 8'h00);
        tick();
        rd(9'h00B, v); check("R5 third edge", v, 8'h02);
        wr(9'h00B, 8'h00);
        repeat (4) tick();
        rd(9'h00B, v); check("R5 steady high", v, 8'h00);
        ext_pin = 1'b0;
        repeat (4) tick();
        rd(9'h00B, v); check("R5 falling edge", v, 8'h00);

        // R6 port change timing
        port_hi = 4'h5;
        repeat (3) tick();
        rd(9'h00B, v); check("R6 not before fourth edge", v, 8'h00);
        tick();
        rd(9'h00B, v); check("R6 fourth edge", v, 8'h01);

        // R7 clear does not stick until port read
        wr(9'h00B, 8'h00);
        rd(9'h00B, v); check("R7 clear blocked", v, 8'h01);
        tick();
        rd(9'h00B, v); check("R7 still set", v, 8'h01);
        port_rd_stb = 1'b1; tick(); port_rd_stb = 1'b0;
        wr(9'h00B, 8'h00);
        rd(9'h00B, v); check("R7 clear after read", v, 8'h00);
        repeat (5) tick();
        rd(9'h00B, v); check("R7 stays clear", v, 8'h00);
        port_hi = 4'hD;
        repeat (4) tick();
        rd(9'h00B, v); check("R6 second change", v, 8'h01);
        port_rd_stb = 1'b1; tick(); port_rd_stb = 1'b0;
        wr(9'h00B, 8'h00);

        // R9 request equation
        periph_pend = 1'b1;
        wr(9'h00B, 8'hC0); #1 check("R9 periph", {7'd0, irq_req}, 8'h01);
        wr(9'h00B, 8'h80); #1 check("R9 no peie", {7'd0, irq_req}, 8'h00);
        wr(9'h00B, 8'h40); #1 check("R9 no gie", {7'd0, irq_req}, 8'h00);
        periph_pend = 1'b0;
        wr(9'h00B, 8'h89); #1 check("R9 port term", {7'd0, irq_req}, 8'h01);
        wr(9'h00B, 8'h09); #1 check("R9 gie masks", {7'd0, irq_req}, 8'h00);
        wr(9'h00B, 8'h92); #1 check("R9 pin term", {7'd0, irq_req}, 8'h01);
        wr(9'h00B, 8'h00);

        // random phase, R1 R2 R3 R8 R9 R11
        model = 8'h00;
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] sel;
            logic [8:0] a;
            logic [7:0] d;
            logic       we, tp;
            rd(9'h00B, v);
            check("R3 random byte", v, model);
            check("R9 random irq", {7'd0, irq_req}, {7'd0, irq_model(model, periph_pend)});
            sel = 3'($urandom_range(0, 7));
            if (sel < 3'd4) a = {sel[1:0], 7'h0B};
            else            a = {2'($urandom), 7'h0B ^ 7'(sel)};
            d  = 8'($urandom);
            we = ($urandom_range(0, 3) == 0);
            tp = ($urandom_range(0, 5) == 0);
            bus_addr = a; bus_wdata = d; bus_we = we; tmr_ovf = tp;
            periph_pend = 1'($urandom);
            if (we && is_hit(a)) model = d;
            if (tp) model[2] = 1'b1;
            tick();
            bus_we = 1'b0; tmr_ovf = 1'b0;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule